// File: doc/BRIEF.md
# Power-Island Control Register Unit

This block is the register front end of a power management unit. Through a plain 32-bit register port, software places a requested 2-bit power state for each of up to 64 logical subsystems into four packed request words. It then issues a set-configuration command. The unit raises a busy flag, holds it for a programmable number of clock cycles, and copies the whole request map into the status map in one step. Software polls busy until it reads 0, then reads the status words back to confirm the new state.

The unit also holds two 32-bit wake-gating words and two sticky wake-status words. It has an interrupt control word that carries an 8-bit cause code, an enable bit, a write-one-to-clear pending bit and a software-interrupt bit. Reads are combinational from the address. Writes take effect on the clock edge that samples `wr_en`.

Top module: `pwr_island_regs`

## Requirements
- R1: After reset, every request, status, wake-control and wake-status word reads 0. Busy (bit 8 at 0x00) reads 0, the interrupt word at 0x08 reads 0, and `irq_o` is low.
- R2: Request words at 0x20+4n (n = 0..3) can be written and read back. Subsystem k owns bits [(2k)%32 +: 2] of word (2k)/32, where 0 is fully on and 3 is off.
- R3: A write to 0x04 with bits 7:0 = 0x01 while idle sets busy for exactly BUSY_CYCLES clock cycles, beginning with the cycle after the write edge.
- R4: Status words at 0x30+4n change only on the edge that clears busy, and they then equal the request words. Writes to status words and to 0x00 have no effect.
- R5: A command write while busy is set is ignored, so the busy period is not lengthened or restarted.
- R6: A command write with an opcode other than 0x01 leaves busy at 0 and the status words unchanged, and it sets the cause code (bits 7:0 of 0x08) to 2.
- R7: When a command ends and both its interrupt-on-completion bit (bit 8 of the command word) and the enable bit (bit 8 of 0x08) are set, the cause becomes 1 and pending (bit 9) becomes 1. Without the enable bit, cause and pending are left unchanged.
- R8: A write to 0x08 loads the enable bit from bit 8. Writing 1 to bit 9 clears pending and the software bit (bit 10). `irq_o` equals pending AND enable.
- R9: Writing 1 to bit 10 of 0x08 sets the software bit and pending.
- R10: Wake-control words at 0x10/0x14 can be read and written. A high wake input bit k whose control bit is set latches sticky into bit k%32 of the wake-status word at 0x18+4·(k/32). A gated-off input does not latch. Writing 1 to a wake-status bit clears it.
- R11: A newly latched wake bit sets the cause to 3, and it sets pending only when the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wake_in | input | WAKE_SRC | Wake source levels |
| irq_o | output | 1 | Interrupt request |

## Verification
Writes are registered, so a written value is visible on `rdata` from the falling edge that follows the capturing rising edge. The bench drives on falling edges and samples one time unit later.

After a command write, busy is observed on BUSY_CYCLES consecutive falling edges and is gone on the next one. The status map, cause and pending bit are valid on that same falling edge, and the bench compares them there.

A wake pulse is latched on the edge that samples it, so wake status and cause are checked one falling edge after the pulse is removed.

// File: rtl/pir_pkg.sv
package pir_pkg;
    localparam int REG_W = 32;

    // Word indices (byte address >> 2)
    localparam logic [5:0] IDX_STAT = 6'd0;
    localparam logic [5:0] IDX_CMD  = 6'd1;
    localparam logic [5:0] IDX_ICS  = 6'd2;
    localparam logic [5:0] IDX_WKC  = 6'd4;
    localparam logic [5:0] IDX_WKS  = 6'd6;
    localparam logic [5:0] IDX_REQ  = 6'd8;
    localparam logic [5:0] IDX_STS  = 6'd12;

    localparam int         BUSY_BIT  = 8;
    localparam int         IOC_BIT   = 8;
    localparam logic [7:0] OPC_APPLY = 8'h01;

    localparam logic [7:0] CAUSE_DONE = 8'd1;
    localparam logic [7:0] CAUSE_ERR  = 8'd2;
    localparam logic [7:0] CAUSE_WAKE = 8'd3;

    typedef struct packed {
        logic       sw;
        logic       pend;
        logic       ie;
        logic [7:0] cause;
    } ics_t;
endpackage

// File: rtl/pir_cmd_seq.sv
module pir_cmd_seq
    import pir_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] cmd_data,
    output logic             busy_o,
    output logic             apply_o,
    output logic             done_ioc_o,
    output logic             err_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic             ioc;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_q, seq_d;
    logic start;

    always_comb begin
        seq_d      = seq_q;
        start      = cmd_wr && !seq_q.busy && (cmd_data[7:0] == OPC_APPLY);
        err_o      = cmd_wr && !seq_q.busy && (cmd_data[7:0] != OPC_APPLY);
        apply_o    = seq_q.busy && (seq_q.cnt == '0);
        done_ioc_o = apply_o && seq_q.ioc;
        if (start) begin
            seq_d.busy = 1'b1;
            seq_d.ioc  = cmd_data[IOC_BIT];
            seq_d.cnt  = CNT_W'(BUSY_CYCLES - 1);
        end else if (seq_q.busy) begin
            if (seq_q.cnt == '0) seq_d.busy = 1'b0;
            else                 seq_d.cnt  = seq_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;

    AST_APPLY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> !busy_o); // R3
    AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cmd_wr)); // R3
    AST_BUSY_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !apply_o) |=> (busy_o && seq_q.cnt == $past(seq_q.cnt) - CNT_W'(1))); // R5
    AST_ERR_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !busy_o); // R6
endmodule

// File: rtl/pir_state_bank.sv
module pir_state_bank
    import pir_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [5:0]                  widx,
    input  logic [REG_W-1:0]            wdata,
    input  logic                        apply,
    output logic [WORDS-1:0][REG_W-1:0] req_o,
    output logic [WORDS-1:0][REG_W-1:0] sts_o
);
    typedef struct packed {
        logic [WORDS-1:0][REG_W-1:0] req;
        logic [WORDS-1:0][REG_W-1:0] sts;
    } bank_t;

    bank_t bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < WORDS; i++) begin
            if (wr_en && widx == 6'(IDX_REQ + i)) bank_d.req[i] = wdata;
        end
        if (apply) bank_d.sts = bank_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign req_o = bank_q.req;
    assign sts_o = bank_q.sts;

    AST_STS_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(sts_o)); // R4
endmodule

// File: rtl/pir_wake_irq.sv
module pir_wake_irq
    import pir_pkg::*;
#(
    parameter int WAKE_WORDS = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [5:0]                       widx,
    input  logic [REG_W-1:0]                 wdata,
    input  logic [WAKE_WORDS-1:0][REG_W-1:0] wake_in,
    input  logic                             done_ioc,
    input  logic                             cmd_err,
    output logic [WAKE_WORDS-1:0][REG_W-1:0] ctrl_o,
    output logic [WAKE_WORDS-1:0][REG_W-1:0] sts_o,
    output ics_t                             ics_o,
    output logic                             irq_o
);
    typedef struct packed {
        logic [WAKE_WORDS-1:0][REG_W-1:0] ctrl;
        logic [WAKE_WORDS-1:0][REG_W-1:0] sts;
        ics_t                             ics;
    } wk_t;

    wk_t  wk_q, wk_d;
    logic [WAKE_WORDS-1:0][REG_W-1:0] gated;
    logic new_wake, sts_wr, ics_wr, sw_set;

    always_comb begin
        wk_d     = wk_q;
        gated    = wake_in & wk_q.ctrl;
        new_wake = |(gated & ~wk_q.sts);
        sts_wr   = 1'b0;
        ics_wr   = wr_en && (widx == IDX_ICS);
        sw_set   = ics_wr && wdata[10];
        for (int i = 0; i < WAKE_WORDS; i++) begin
            if (wr_en && widx == 6'(IDX_WKC + i)) wk_d.ctrl[i] = wdata;
            if (wr_en && widx == 6'(IDX_WKS + i)) begin
                wk_d.sts[i] = wk_q.sts[i] & ~wdata;
                sts_wr      = 1'b1;
            end
        end
        wk_d.sts = wk_d.sts | gated;
        if (ics_wr) begin
            wk_d.ics.ie = wdata[8];
            if (wdata[9]) begin
                wk_d.ics.pend = 1'b0;
                wk_d.ics.sw   = 1'b0;
            end
            if (wdata[10]) begin
                wk_d.ics.sw   = 1'b1;
                wk_d.ics.pend = 1'b1;
            end
        end
        if (new_wake) begin
            wk_d.ics.cause = CAUSE_WAKE;
            if (wk_q.ics.ie) wk_d.ics.pend = 1'b1;
        end
        if (cmd_err) begin
            wk_d.ics.cause = CAUSE_ERR;
            if (wk_q.ics.ie) wk_d.ics.pend = 1'b1;
        end
        if (done_ioc && wk_q.ics.ie) begin
            wk_d.ics.cause = CAUSE_DONE;
            wk_d.ics.pend  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign ctrl_o = wk_q.ctrl;
    assign sts_o  = wk_q.sts;
    assign ics_o  = wk_q.ics;
    assign irq_o  = wk_q.ics.pend && wk_q.ics.ie;

    AST_PEND_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wk_q.ics.pend) |-> $past(sw_set || new_wake || cmd_err || done_ioc)); // R7
    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((sts_o & $past(sts_o)) == $past(sts_o))); // R10
    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(new_wake || cmd_err || (done_ioc && wk_q.ics.ie)) |=> $stable(wk_q.ics.cause)); // R11
endmodule

// File: rtl/pwr_island_regs.sv
module pwr_island_regs
    import pir_pkg::*;
#(
    parameter int NUM_SUBSYS  = 64,
    parameter int STATE_BITS  = 2,
    parameter int WAKE_SRC    = 64,
    parameter int BUSY_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [WAKE_SRC-1:0] wake_in,
    output logic                irq_o
);
    localparam int STATE_WORDS = (NUM_SUBSYS * STATE_BITS + REG_W - 1) / REG_W;
    localparam int WAKE_WORDS  = (WAKE_SRC + REG_W - 1) / REG_W;

    logic [5:0] widx;
    logic       busy, apply, done_ioc, cmd_err;
    logic [STATE_WORDS-1:0][REG_W-1:0] req_w, sts_w;
    logic [WAKE_WORDS-1:0][REG_W-1:0]  wk_ctrl, wk_sts, wake_pad;
    ics_t ics;

    assign widx     = addr[7:2];
    assign wake_pad = (WAKE_WORDS * REG_W)'(wake_in);

    pir_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(wr_en && widx == IDX_CMD), .cmd_data(wdata),
        .busy_o(busy), .apply_o(apply), .done_ioc_o(done_ioc), .err_o(cmd_err)
    );

    pir_state_bank #(.WORDS(STATE_WORDS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(widx), .wdata(wdata),
        .apply(apply), .req_o(req_w), .sts_o(sts_w)
    );

    pir_wake_irq #(.WAKE_WORDS(WAKE_WORDS)) u_wk (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(widx), .wdata(wdata),
        .wake_in(wake_pad), .done_ioc(done_ioc), .cmd_err(cmd_err),
        .ctrl_o(wk_ctrl), .sts_o(wk_sts), .ics_o(ics), .irq_o(irq_o)
    );

    always_comb begin
        rdata = '0;
        if (widx == IDX_STAT) rdata[BUSY_BIT] = busy;
        if (widx == IDX_ICS)  rdata = REG_W'(ics);
        for (int i = 0; i < WAKE_WORDS; i++) begin
            if (widx == 6'(IDX_WKC + i)) rdata = wk_ctrl[i];
            if (widx == 6'(IDX_WKS + i)) rdata = wk_sts[i];
        end
        for (int i = 0; i < STATE_WORDS; i++) begin
            if (widx == 6'(IDX_REQ + i)) rdata = req_w[i];
            if (widx == 6'(IDX_STS + i)) rdata = sts_w[i];
        end
    end

    AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(done_ioc || cmd_err || wr_en) || $past(|wake_pad))); // R8
endmodule

// File: tb/pwr_island_regs_tb.sv
module pwr_island_regs_tb;
    localparam int NB = 8;

    logic        clk = 0, rst_n = 0, wr_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic [63:0] wake_in = 0;
    logic        irq_o;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [31:0] mreq [4];
    logic [31:0] msts [4];
    logic [7:0]  e_cause = 0;
    bit e_ie = 0, e_pend = 0, e_sw = 0;

    always #5 clk = ~clk;

    pwr_island_regs #(.BUSY_CYCLES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wake_in(wake_in), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_ics();
        return {21'd0, e_sw, e_pend, e_ie, e_cause};
    endfunction

    function automatic void set_field(int k, logic [1:0] v);
        mreq[(2 * k) / 32][(2 * k) % 32 +: 2] = v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic run_cmd(bit ioc, bit inject, output int n);
        logic [31:0] v;
        @(negedge clk);
        addr = 8'h04; wdata = 32'h1 | (32'(ioc) << 8); wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            wr_en = 0;
            rd(8'h00, v);
            if (!v[8]) break;
            n++;
            if (inject && i == 1) begin
                addr = 8'h04; wdata = 32'h1; wr_en = 1;
            end
            @(negedge clk);
        end
        wr_en = 0;
        for (int j = 0; j < 4; j++) msts[j] = mreq[j];
        if (ioc && e_ie) begin e_cause = 8'd1; e_pend = 1; end
    endtask

    task automatic chk_status(string tag);
        logic [31:0] v;
        for (int j = 0; j < 4; j++) begin
            rd(8'h30 + 8'(4 * j), v);
            chk(tag, v, msts[j]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd20240611));
        for (int j = 0; j < 4; j++) begin mreq[j] = 0; msts[j] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 64; a += 4) begin
            rd(8'(a), v);
            chk("R1 reset word", v, 32'h0);
        end
        chk("R1 irq", 32'(irq_o), 32'h0);

        // R2 request words and field placement
        for (int j = 0; j < 4; j++) mreq[j] = 32'hA5A5_0000 + 32'(j);
        set_field(0, 2'd3); set_field(17, 2'd2); set_field(63, 2'd1);
        for (int j = 0; j < 4; j++) wr(8'h20 + 8'(4 * j), mreq[j]);
        rd(8'h20, v); chk("R2 sub0 field", 32'(v[1:0]), 32'd3);
        rd(8'h24, v); chk("R2 sub17 field", 32'(v[3:2]), 32'd2);
        rd(8'h2C, v); chk("R2 sub63 field", 32'(v[31:30]), 32'd1);
        for (int j = 0; j < 4; j++) begin
            rd(8'h20 + 8'(4 * j), v);
            chk("R2 readback", v, mreq[j]);
        end

        // R4 status is read-only and untouched before a command
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        chk_status("R4 status before apply");
        rd(8'h00, v); chk("R4 status reg write ignored", v, 32'h0);

        // R3/R4/R7/R8 directed apply with enable and completion interrupt
        wr(8'h08, 32'h100); e_ie = 1;
        run_cmd(1, 0, n);
        chk("R3 busy length", 32'(n), 32'(NB));
        chk_status("R4 status after apply");
        rd(8'h08, v); chk("R7 cause done + pending", v, exp_ics());
        chk("R8 irq high", 32'(irq_o), 32'h1);
        wr(8'h08, 32'h300); e_pend = 0; e_sw = 0;
        rd(8'h08, v); chk("R8 pending cleared", v, exp_ics());
        chk("R8 irq low", 32'(irq_o), 32'h0);

        // R5 command during busy ignored
        mreq[1] = 32'h1234_5678; wr(8'h24, mreq[1]);
        run_cmd(0, 1, n);
        chk("R5 busy not extended", 32'(n), 32'(NB));
        chk_status("R5 status after apply");

        // R6 unknown opcode
        mreq[2] = 32'hDEAD_BEEF; wr(8'h28, mreq[2]);
        wr(8'h04, 32'h0000_0105);
        rd(8'h00, v); chk("R6 no busy", v, 32'h0);
        e_cause = 8'd2; e_pend = 1;
        rd(8'h08, v); chk("R6 cause error", v, exp_ics());
        rd(8'h38, v); chk("R6 status unchanged", v, msts[2]);
        wr(8'h08, 32'h300); e_pend = 0;

        // R9 software interrupt
        wr(8'h08, 32'h500); e_sw = 1; e_pend = 1;
        rd(8'h08, v); chk("R9 software bit", v, exp_ics());
        chk("R9 irq", 32'(irq_o), 32'h1);
        wr(8'h08, 32'h300); e_sw = 0; e_pend = 0;
        rd(8'h08, v); chk("R9 cleared", v, exp_ics());

        // R10/R11 wake gating
        wr(8'h10, 32'h0000_00F0);
        wr(8'h14, 32'h0000_0000);
        rd(8'h10, v); chk("R10 ctrl readback", v, 32'h0000_00F0);
        @(negedge clk); wake_in = 64'h0000_0100_0000_0011;
        @(negedge clk); wake_in = 0;
        rd(8'h18, v); chk("R10 gated latch", v, 32'h0000_0010);
        rd(8'h1C, v); chk("R10 blocked source", v, 32'h0);
        e_cause = 8'd3; e_pend = 1;
        rd(8'h08, v); chk("R11 wake cause", v, exp_ics());
        wr(8'h18, 32'h0000_0010);
        rd(8'h18, v); chk("R10 w1c", v, 32'h0);
        wr(8'h08, 32'h000); e_ie = 0;
        wr(8'h08, 32'h200); e_pend = 0;
        wr(8'h10, 32'hFFFF_FFFF);
        @(negedge clk); wake_in = 64'h8;
        @(negedge clk); wake_in = 0;
        e_cause = 8'd3;
        rd(8'h08, v); chk("R11 no pending without enable", v, exp_ics());
        rd(8'h18, v); chk("R10 ungated latch", v, 32'h8);
        wr(8'h18, 32'hFFFF_FFFF);

        // Random request maps
        for (int it = 0; it < 25; it++) begin
            bit ie, ioc;
            int k;
            ie = 1'($urandom); ioc = 1'($urandom);
            wr(8'h08, {22'd0, 1'b1, ie, 8'd0}); e_ie = ie; e_pend = 0; e_sw = 0;
            for (int j = 0; j < 4; j++) mreq[j] = $urandom;
            k = $urandom_range(0, 63);
            set_field(k, 2'($urandom));
            for (int j = 0; j < 4; j++) wr(8'h20 + 8'(4 * j), mreq[j]);
            run_cmd(ioc, (it % 5) == 0, n);
            chk("R3 random busy length", 32'(n), 32'(NB));
            chk_status("R4 random status");
            rd(8'h08, v); chk("R7 random ics", v, exp_ics());
            chk("R8 random irq", 32'(irq_o), 32'(e_pend & e_ie));
        end

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule